// File: doc/BRIEF.md
# FIFO Level and Status Tracker

This block keeps the occupancy counts of a serial controller's transmit and receive FIFOs and builds a 7-bit status word from those counts and from the controller's two protocol state machines. It does not hold any FIFO data and does not drive the serial bus. The surrounding logic sends it single-cycle push and pop strobes for each FIFO. It also supplies a level-sensitive enable, abort pulses, and an idle indication from the master and the slave state machines.

Each count is a register that moves by one entry per cycle. Both counts saturate at their parameterised depth and at zero. Disabling the controller drops both counts to zero, and so does a transmit abort. An abort of a slave bulk transmission empties only the transmit count. The FIFO flags in the status word are decoded from the counts in the same cycle, so the flags follow the counts with no extra delay. The two activity flags are sticky. Each one stays set until its state machine is idle while the controller is disabled. No status bit raises an interrupt.

Top module: `fifo_level_status`

## Requirements
- R1: While `enable` is 1 and no clear applies, `tx_level` rises by one on the clock after a `tx_push` without a `tx_pop`, and falls by one on the clock after a `tx_pop` without a `tx_push`.
- R2: A push and a pop in the same cycle leave a level unchanged. A push when the level equals the depth is ignored, and a pop when the level is zero is ignored.
- R3: `tx_level` is 0 on the clock after any cycle in which `enable` is 0, `tx_abort` is 1 or `slv_bulk_abort` is 1. A push in that cycle is ignored.
- R4: `rx_level` counts `rx_push`/`rx_pop` in the same way as R1 and R2. It is 0 on the clock after any cycle with `enable` 0 or `tx_abort` 1, and `slv_bulk_abort` alone does not touch it.
- R5: Bits 1 to 4 of `status` are decoded from the current levels. Bit 1 = `tx_level` below TX_DEPTH. Bit 2 = `tx_level` equals 0. Bit 3 = `rx_level` above 0. Bit 4 = `rx_level` equals RX_DEPTH.
- R6: From the clock after `enable` goes to 0, and for as long as it stays 0, `status[4:1]` reads 4'b0011.
- R7: Status bit 5 (master active) is set on the clock after a cycle with `mst_idle` 0. It is cleared on the clock after a cycle with `mst_idle` 1 and `enable` 0, and it holds its value otherwise. Status bit 0 is the OR of bits 5 and 6.
- R8: Status bit 6 (slave active) follows R7 with `slv_idle` in place of `mst_idle`.
- R9: After a clock with `rst_n` low, both levels are 0 and `status` is 7'h06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enable; 0 clears the levels and allows the activity flags to drop |
| tx_push | input | 1 | One entry written into the transmit FIFO |
| tx_pop | input | 1 | One entry taken from the transmit FIFO |
| rx_push | input | 1 | One entry written into the receive FIFO |
| rx_pop | input | 1 | One entry taken from the receive FIFO |
| tx_abort | input | 1 | Transmit abort pulse; clears both levels |
| slv_bulk_abort | input | 1 | Slave bulk-transmit abort pulse; clears the transmit level |
| mst_idle | input | 1 | Master state machine is idle |
| slv_idle | input | 1 | Slave state machine is idle |
| tx_level | output | $clog2(TX_DEPTH)+1 | Transmit FIFO occupancy |
| rx_level | output | $clog2(RX_DEPTH)+1 | Receive FIFO occupancy |
| status | output | 7 | {slave active, master active, rx full, rx not empty, tx empty, tx not full, activity} |

## Verification
Every piece of state in this block can be seen at the ports. A wrong count shows up as a wrong level value on the next clock edge. It also flips one of the decoded FIFO flags at the full or empty boundary in that same cycle. A wrong activity flag shows as a wrong bit 0, 5 or 6 on the clock after the idle/enable combination that should have moved it. For that reason a reference model is compared on every clock, which pins each fault to the first cycle where it happens. The stimulus phases fill each FIFO to its depth, drain it past zero, pulse each abort and toggle the enable.

// File: rtl/flst_pkg.sv
// Package: shared bit positions of the status word.
// Assumes: consumers index the status vector by these constants only.
package flst_pkg;
    localparam int STATUS_W     = 7;
    localparam int ST_ACTIVITY  = 0;
    localparam int ST_TX_NFULL  = 1;
    localparam int ST_TX_EMPTY  = 2;
    localparam int ST_RX_NEMPTY = 3;
    localparam int ST_RX_FULL   = 4;
    localparam int ST_MST_ACT   = 5;
    localparam int ST_SLV_ACT   = 6;
    localparam logic [STATUS_W-1:0] STATUS_RST = 7'h06;
endpackage

// File: rtl/flst_level_counter.sv
// Module: saturating occupancy counter for one FIFO.
// Does: counts single-entry pushes and pops, saturates at DEPTH and 0,
//       and forces zero on a synchronous clear.
// Assumes: push/pop are one-cycle strobes, at most one entry each per cycle.
module flst_level_counter #(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    output logic [LW-1:0] level,
    output logic          is_full,
    output logic          is_empty
);
    localparam logic [LW-1:0] FULL_VAL = LW'(DEPTH);

    logic [LW-1:0] level_q;
    logic          do_inc;
    logic          do_dec;

    // Decide the step from the strobes and the saturation bounds.
    always_comb begin
        do_inc = push && !pop && (level_q != FULL_VAL);
        do_dec = pop && !push && (level_q != '0);
    end

    // Level register: clear wins, then one step up or down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            level_q <= '0;
        end else if (do_inc) begin
            level_q <= level_q + 1'b1;
        end else if (do_dec) begin
            level_q <= level_q - 1'b1;
        end
    end

    // Decode the boundary flags from the registered level.
    always_comb begin
        level    = level_q;
        is_full  = (level_q == FULL_VAL);
        is_empty = (level_q == '0);
    end

    AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= FULL_VAL);                                           // R2
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (level_q == '0));                                     // R3
    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clear) |=> $stable(level_q));                  // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear && level_q != FULL_VAL)
        |=> (level_q == $past(level_q) + 1'b1));                        // R1
    AST_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clear && level_q != '0)
        |=> (level_q == $past(level_q) - 1'b1));                        // R1
endmodule

// File: rtl/flst_activity_flag.sv
// Module: sticky activity flag for one protocol state machine.
// Does: sets while the machine is busy; clears only when the machine is
//       idle and the controller is disabled; holds otherwise.
// Assumes: idle is a synchronous level from the state machine.
module flst_activity_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic idle,
    output logic active
);
    logic act_q;

    // Flag register: busy sets, idle-and-disabled clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (!idle) begin
            act_q <= 1'b1;
        end else if (!enable) begin
            act_q <= 1'b0;
        end
    end

    // Drive the output from the register.
    always_comb active = act_q;

    AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> act_q);                                               // R7
    AST_ACT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && enable) |=> act_q);                                   // R7
    AST_ACT_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && idle) |=> !act_q);                                   // R8
endmodule

// File: rtl/fifo_level_status.sv
// Module: FIFO level and status tracker (top).
// Does: keeps TX/RX occupancy counts and assembles the 7-bit status word.
// Assumes: enable is a level; tx_abort and slv_bulk_abort are pulses;
//          the FIFO storage itself lives elsewhere and uses these levels.
module fifo_level_status
    import flst_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_LW   = $clog2(TX_DEPTH) + 1,
    localparam int RX_LW   = $clog2(RX_DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                tx_push,
    input  logic                tx_pop,
    input  logic                rx_push,
    input  logic                rx_pop,
    input  logic                tx_abort,
    input  logic                slv_bulk_abort,
    input  logic                mst_idle,
    input  logic                slv_idle,
    output logic [TX_LW-1:0]    tx_level,
    output logic [RX_LW-1:0]    rx_level,
    output logic [STATUS_W-1:0] status
);
    logic tx_clear, rx_clear;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic mst_act, slv_act;

    // Clear sources: both counts on disable or transmit abort; TX also on bulk abort.
    always_comb begin
        tx_clear = !enable || tx_abort || slv_bulk_abort;
        rx_clear = !enable || tx_abort;
    end

    flst_level_counter #(.DEPTH(TX_DEPTH)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .clear(tx_clear),
        .push(tx_push), .pop(tx_pop),
        .level(tx_level), .is_full(tx_full), .is_empty(tx_empty)
    );

    flst_level_counter #(.DEPTH(RX_DEPTH)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .clear(rx_clear),
        .push(rx_push), .pop(rx_pop),
        .level(rx_level), .is_full(rx_full), .is_empty(rx_empty)
    );

    flst_activity_flag u_mst_act (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .idle(mst_idle), .active(mst_act)
    );

    flst_activity_flag u_slv_act (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .idle(slv_idle), .active(slv_act)
    );

    // Assemble the status word from the flags.
    always_comb begin
        status               = '0;
        status[ST_ACTIVITY]  = mst_act || slv_act;
        status[ST_TX_NFULL]  = !tx_full;
        status[ST_TX_EMPTY]  = tx_empty;
        status[ST_RX_NEMPTY] = !rx_empty;
        status[ST_RX_FULL]   = rx_full;
        status[ST_MST_ACT]   = mst_act;
        status[ST_SLV_ACT]   = slv_act;
    end

    AST_DIS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (status[4:1] == 4'b0011));                          // R6
    AST_RX_BULK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tx_abort && !rx_push && !rx_pop) |=> $stable(rx_level)); // R4
    AST_TX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_TX_EMPTY] |-> (tx_level == '0));                      // R5
endmodule

// File: tb/tb_fifo_level_status.sv
module tb_fifo_level_status;
    localparam int CLK_PERIOD = 10;
    localparam int TXD = 8;
    localparam int RXD = 8;
    localparam int TLW = $clog2(TXD) + 1;
    localparam int RLW = $clog2(RXD) + 1;
    localparam int NCYC = 6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic tx_abort = 1'b0, slv_bulk_abort = 1'b0, mst_idle = 1'b1, slv_idle = 1'b1;
    logic [TLW-1:0] tx_level;
    logic [RLW-1:0] rx_level;
    logic [6:0]     status;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    int  m_tx = 0, m_rx = 0;
    bit  m_mact = 1'b0, m_sact = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_level_status #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
        .tx_abort(tx_abort), .slv_bulk_abort(slv_bulk_abort),
        .mst_idle(mst_idle), .slv_idle(slv_idle),
        .tx_level(tx_level), .rx_level(rx_level), .status(status)
    );

    function automatic logic [6:0] exp_status();
        logic [6:0] s;
        s[0] = m_mact | m_sact;
        s[1] = (m_tx < TXD);
        s[2] = (m_tx == 0);
        s[3] = (m_rx > 0);
        s[4] = (m_rx == RXD);
        s[5] = m_mact;
        s[6] = m_sact;
        return s;
    endfunction

    task automatic compare_all(input string tag);
        logic [6:0] es;
        es = exp_status();
        vectors++;
        if (int'(tx_level) != m_tx) begin
            miscompares++;
            $display("FAIL %s R1 R2 R3 tx_level actual=%0d expected=%0d", tag, tx_level, m_tx);
        end
        vectors++;
        if (int'(rx_level) != m_rx) begin
            miscompares++;
            $display("FAIL %s R4 rx_level actual=%0d expected=%0d", tag, rx_level, m_rx);
        end
        vectors++;
        if (status[4:1] != es[4:1]) begin
            miscompares++;
            $display("FAIL %s R5 R6 status[4:1] actual=%b expected=%b", tag, status[4:1], es[4:1]);
        end
        vectors++;
        if ({status[6:5], status[0]} != {es[6:5], es[0]}) begin
            miscompares++;
            $display("FAIL %s R7 R8 activity bits actual=%b expected=%b",
                     tag, {status[6:5], status[0]}, {es[6:5], es[0]});
        end
    endtask

    // Reference model step: applied with the inputs held over the coming edge.
    task automatic model_step();
        if (!enable || tx_abort || slv_bulk_abort) m_tx = 0;
        else if (tx_push && !tx_pop && m_tx < TXD) m_tx++;
        else if (tx_pop && !tx_push && m_tx > 0) m_tx--;
        if (!enable || tx_abort) m_rx = 0;
        else if (rx_push && !rx_pop && m_rx < RXD) m_rx++;
        else if (rx_pop && !rx_push && m_rx > 0) m_rx--;
        if (!mst_idle) m_mact = 1'b1; else if (!enable) m_mact = 1'b0;
        if (!slv_idle) m_sact = 1'b1; else if (!enable) m_sact = 1'b0;
    endtask

    function automatic bit chance(input int pct);
        return ($urandom_range(99) < pct);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (tx_level != '0 || rx_level != '0 || status != 7'h06) begin
            miscompares++;
            $display("FAIL R9 reset state actual=%0d/%0d/%h expected=0/0/06",
                     tx_level, rx_level, status);
        end
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            int ph;
            ph = (c / 400) % 6;
            enable         = (ph == 4) ? chance(65) : !chance(1);
            tx_push        = chance(ph == 0 ? 85 : (ph == 1 ? 15 : 50));
            tx_pop         = chance(ph == 0 ? 15 : (ph == 1 ? 85 : 50));
            rx_push        = chance(ph == 0 ? 85 : (ph == 1 ? 15 : 50));
            rx_pop         = chance(ph == 0 ? 15 : (ph == 1 ? 85 : 50));
            tx_abort       = chance(ph == 3 ? 4 : 0);
            slv_bulk_abort = chance(ph == 3 ? 6 : 0);
            mst_idle       = !chance(ph == 5 ? 30 : 8);
            slv_idle       = !chance(ph == 5 ? 30 : 8);
            model_step();
            @(negedge clk);
            compare_all($sformatf("cycle %0d", c));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule